// File: doc/BRIEF.md
# Page-Aware Word Address Counter for a Serial EEPROM Slave

This block holds the internal word address of a two-wire serial EEPROM slave. The protocol engine loads it with the address named by the host. That address is built from the page-select bits carried in the device-address byte and the word-address byte that follows. The engine then steps the counter once for each data byte moved. Between transactions the counter keeps the last address used plus one, so a later current-address read resumes where the previous access stopped.

The step rule depends on the operation. During a write, only the offset inside the page advances, and the byte after the last one in the page lands on the first byte of the same page. During a read, the whole address advances, and the byte after the top of the array is byte zero. A size code selects one of four array sizes, which sets the address width and the page size. In the largest size, the top address bits are not stored across a current-address read; they are taken again from that read's device-address byte.

Top module: `eeprom_addr_ctr`

## Requirements
- R1: While rst_ni is low, addr_o is zero.
- R2: A load sets addr_o to {page bits, word_i}. Size code n (0..3) gives an address width of 8+n bits, and only the low n bits of page_i are used; every address bit above 7+n is zero.
- R3: A load wins over a step or a current-read strobe asserted in the same cycle.
- R4: A write step (incr_i with wr_i=1) adds one to the page offset: the low 3 bits for size code 0, the low 4 bits for codes 1 to 3. All higher bits stay unchanged.
- R5: A write step from the last byte of a page moves to the first byte of that same page.
- R6: A read step (incr_i with wr_i=0) adds one to the full address, carrying across page boundaries.
- R7: A read step from the top address of the configured array (all 8+n bits set) gives zero.
- R8: With no load, step or current-read strobe, addr_o holds its value.
- R9: With size code 3, a current-read strobe replaces bits 10:8 with page_i and keeps bits 7:0; with other codes the strobe leaves the address unchanged. The strobe wins over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| size_i | input | 2 | Array size code n: 256 << n bytes |
| load_i | input | 1 | Load address from page_i and word_i |
| incr_i | input | 1 | Step after one data byte |
| wr_i | input | 1 | Operation type for a step: 1 write, 0 read |
| cur_rd_i | input | 1 | Current-address read has started |
| page_i | input | 3 | Page-select bits from the device-address byte |
| word_i | input | 8 | Word-address byte |
| addr_o | output | 11 | Current word address |

## Verification
Each command is captured by the one address register, so its result appears on addr_o one rising edge after the command is presented, and never later. The bench applies a command on a falling edge and removes it on the next falling edge. It reads addr_o at that second falling edge, after exactly one capturing edge. Sequences of steps compare the address after every single edge. The hold case reads the address over several idle edges to show that it does not drift.

// File: rtl/eeprom_addr_pkg.sv
package eeprom_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_CURRD = 2'd2,
    OP_STEP  = 2'd3
  } addr_op_e;
endpackage

// File: rtl/eac_geom.sv
module eac_geom #(
  parameter int unsigned WORD_W        = 8,
  parameter int unsigned PAGE_SEL_W    = 3,
  parameter int unsigned SMALL_PG_LOG2 = 3,
  parameter int unsigned LARGE_PG_LOG2 = 4,
  localparam int unsigned ADDR_W       = WORD_W + PAGE_SEL_W,
  localparam int unsigned SZ_W         = $clog2(PAGE_SEL_W + 1)
) (
  input  logic [SZ_W-1:0]       size_i,
  output logic [ADDR_W-1:0]     arr_mask_o,
  output logic [ADDR_W-1:0]     pg_mask_o,
  output logic [PAGE_SEL_W-1:0] sel_mask_o
);
  localparam int unsigned N_SZ = PAGE_SEL_W + 1;

  logic [ADDR_W-1:0]     arr_tab [N_SZ];
  logic [ADDR_W-1:0]     pg_tab  [N_SZ];
  logic [PAGE_SEL_W-1:0] sel_tab [N_SZ];

  for (genvar g = 0; g < N_SZ; g++) begin : g_size
    localparam int unsigned PGL = (g == 0) ? SMALL_PG_LOG2 : LARGE_PG_LOG2;
    assign arr_tab[g] = {ADDR_W{1'b1}} >> (PAGE_SEL_W - g);
    assign pg_tab[g]  = {ADDR_W{1'b1}} >> (ADDR_W - PGL);
    assign sel_tab[g] = {PAGE_SEL_W{1'b1}} >> (PAGE_SEL_W - g);
  end

  always_comb begin
    arr_mask_o = arr_tab[0];
    pg_mask_o  = pg_tab[0];
    sel_mask_o = sel_tab[0];
    for (int i = 0; i < N_SZ; i++) begin
      if (int'(size_i) == i) begin
        arr_mask_o = arr_tab[i];
        pg_mask_o  = pg_tab[i];
        sel_mask_o = sel_tab[i];
      end
    end
  end
endmodule

// File: rtl/eac_ctrl.sv
module eac_ctrl
  import eeprom_addr_pkg::*;
(
  input  logic     load_i,
  input  logic     cur_rd_i,
  input  logic     incr_i,
  output addr_op_e op_o
);
  // priority: load, then current-read reload, then step
  always_comb begin
    if (load_i)        op_o = OP_LOAD;
    else if (cur_rd_i) op_o = OP_CURRD;
    else if (incr_i)   op_o = OP_STEP;
    else               op_o = OP_HOLD;
  end
endmodule

// File: rtl/eac_next.sv
module eac_next
  import eeprom_addr_pkg::*;
#(
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned PAGE_SEL_W = 3,
  localparam int unsigned ADDR_W    = WORD_W + PAGE_SEL_W
) (
  input  addr_op_e              op_i,
  input  logic                  wr_i,
  input  logic                  size_max_i,
  input  logic [ADDR_W-1:0]     cur_i,
  input  logic [WORD_W-1:0]     word_i,
  input  logic [PAGE_SEL_W-1:0] page_i,
  input  logic [ADDR_W-1:0]     arr_mask_i,
  input  logic [ADDR_W-1:0]     pg_mask_i,
  input  logic [PAGE_SEL_W-1:0] sel_mask_i,
  output logic [ADDR_W-1:0]     nxt_o
);
  logic [ADDR_W-1:0] plus1;
  logic [ADDR_W-1:0] step_wr;
  logic [ADDR_W-1:0] step_rd;

  assign plus1   = cur_i + 1'b1;
  assign step_wr = (cur_i & ~pg_mask_i) | (plus1 & pg_mask_i);
  assign step_rd = plus1 & arr_mask_i;

  always_comb begin
    unique case (op_i)
      OP_LOAD:  nxt_o = {page_i & sel_mask_i, word_i};
      OP_CURRD: nxt_o = size_max_i ? {page_i, cur_i[WORD_W-1:0]} : cur_i;
      OP_STEP:  nxt_o = wr_i ? step_wr : step_rd;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/eeprom_addr_ctr.sv
module eeprom_addr_ctr
  import eeprom_addr_pkg::*;
#(
  parameter int unsigned WORD_W        = 8,
  parameter int unsigned PAGE_SEL_W    = 3,
  parameter int unsigned SMALL_PG_LOG2 = 3,
  parameter int unsigned LARGE_PG_LOG2 = 4,
  localparam int unsigned ADDR_W       = WORD_W + PAGE_SEL_W,
  localparam int unsigned SZ_W         = $clog2(PAGE_SEL_W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SZ_W-1:0]       size_i,
  input  logic                  load_i,
  input  logic                  incr_i,
  input  logic                  wr_i,
  input  logic                  cur_rd_i,
  input  logic [PAGE_SEL_W-1:0] page_i,
  input  logic [WORD_W-1:0]     word_i,
  output logic [ADDR_W-1:0]     addr_o
);
  logic [ADDR_W-1:0]     arr_mask;
  logic [ADDR_W-1:0]     pg_mask;
  logic [PAGE_SEL_W-1:0] sel_mask;
  logic [ADDR_W-1:0]     addr_q;
  logic [ADDR_W-1:0]     addr_d;
  logic                  size_max;
  addr_op_e              op;

  assign size_max = (size_i == SZ_W'(PAGE_SEL_W));

  eac_geom #(
    .WORD_W       (WORD_W),
    .PAGE_SEL_W   (PAGE_SEL_W),
    .SMALL_PG_LOG2(SMALL_PG_LOG2),
    .LARGE_PG_LOG2(LARGE_PG_LOG2)
  ) u_geom (
    .size_i    (size_i),
    .arr_mask_o(arr_mask),
    .pg_mask_o (pg_mask),
    .sel_mask_o(sel_mask)
  );

  eac_ctrl u_ctrl (
    .load_i  (load_i),
    .cur_rd_i(cur_rd_i),
    .incr_i  (incr_i),
    .op_o    (op)
  );

  eac_next #(
    .WORD_W    (WORD_W),
    .PAGE_SEL_W(PAGE_SEL_W)
  ) u_next (
    .op_i      (op),
    .wr_i      (wr_i),
    .size_max_i(size_max),
    .cur_i     (addr_q),
    .word_i    (word_i),
    .page_i    (page_i),
    .arr_mask_i(arr_mask),
    .pg_mask_i (pg_mask),
    .sel_mask_i(sel_mask),
    .nxt_o     (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/eeprom_addr_ctr_chk.sv
module eeprom_addr_ctr_chk #(
  parameter int unsigned WORD_W        = 8,
  parameter int unsigned PAGE_SEL_W    = 3,
  parameter int unsigned LARGE_PG_LOG2 = 4,
  localparam int unsigned ADDR_W       = WORD_W + PAGE_SEL_W,
  localparam int unsigned SZ_W         = $clog2(PAGE_SEL_W + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [SZ_W-1:0]       size_i,
  input logic                  load_i,
  input logic                  incr_i,
  input logic                  wr_i,
  input logic                  cur_rd_i,
  input logic [PAGE_SEL_W-1:0] page_i,
  input logic [WORD_W-1:0]     word_i,
  input logic [ADDR_W-1:0]     addr_o
);
  logic wstep, rstep, idle, crd_max;
  assign wstep   = incr_i && wr_i && !load_i && !cur_rd_i;
  assign rstep   = incr_i && !wr_i && !load_i && !cur_rd_i;
  assign idle    = !load_i && !incr_i && !cur_rd_i;
  assign crd_max = cur_rd_i && !load_i && (size_i == SZ_W'(PAGE_SEL_W));

  AST_LOAD_LOW_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o[WORD_W-1:0] == $past(word_i)); // R2 R3

  AST_WRITE_KEEPS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wstep |=> (addr_o >> LARGE_PG_LOG2) == ($past(addr_o) >> LARGE_PG_LOG2)); // R4

  AST_WRITE_PAGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wstep && size_i != '0 && addr_o[LARGE_PG_LOG2-1:0] == '1)
      |=> addr_o[LARGE_PG_LOG2-1:0] == '0); // R5

  AST_READ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstep |=> addr_o == (($past(addr_o) + 1'b1)
                         & ({ADDR_W{1'b1}} >> (PAGE_SEL_W - $past(size_i))))); // R6 R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(addr_o)); // R8

  AST_CURRD_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crd_max |=> (addr_o[ADDR_W-1:WORD_W] == $past(page_i))
                && (addr_o[WORD_W-1:0] == $past(addr_o[WORD_W-1:0]))); // R9
endmodule

bind eeprom_addr_ctr eeprom_addr_ctr_chk #(
  .WORD_W       (WORD_W),
  .PAGE_SEL_W   (PAGE_SEL_W),
  .LARGE_PG_LOG2(LARGE_PG_LOG2)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .size_i  (size_i),
  .load_i  (load_i),
  .incr_i  (incr_i),
  .wr_i    (wr_i),
  .cur_rd_i(cur_rd_i),
  .page_i  (page_i),
  .word_i  (word_i),
  .addr_o  (addr_o)
);

// File: tb/eeprom_addr_ctr_test.sv
`timescale 1ns/1ps
module eeprom_addr_ctr_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [1:0]  size_i = '0;
  logic        load_i = 1'b0;
  logic        incr_i = 1'b0;
  logic        wr_i = 1'b0;
  logic        cur_rd_i = 1'b0;
  logic [2:0]  page_i = '0;
  logic [7:0]  word_i = '0;
  logic [10:0] addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  eeprom_addr_ctr uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .size_i(size_i), .load_i(load_i),
    .incr_i(incr_i), .wr_i(wr_i), .cur_rd_i(cur_rd_i), .page_i(page_i),
    .word_i(word_i), .addr_o(addr_o)
  );

  task automatic check(input string req, input logic [10:0] exp);
    checks++;
    if (addr_o !== exp) begin
      fails++;
      $display("FAIL %s addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // apply one command for one edge, sample at the following falling edge
  task automatic cmd(input bit ld, input bit inc, input bit wr, input bit crd,
                     input logic [2:0] pg, input logic [7:0] wd);
    @(negedge clk_i);
    load_i = ld; incr_i = inc; wr_i = wr; cur_rd_i = crd; page_i = pg; word_i = wd;
    @(negedge clk_i);
    load_i = 1'b0; incr_i = 1'b0; cur_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", 11'h000);
  endtask

  task automatic t_load();
    size_i = 2'd3; cmd(1, 0, 0, 0, 3'd5, 8'hA7); check("R2", 11'h5A7);
    size_i = 2'd0; cmd(1, 0, 0, 0, 3'd7, 8'h12); check("R2", 11'h012);
    size_i = 2'd1; cmd(1, 0, 0, 0, 3'd3, 8'h12); check("R2", 11'h112);
    size_i = 2'd2; cmd(1, 0, 0, 0, 3'd6, 8'h34); check("R2", 11'h234);
  endtask

  task automatic t_write_page();
    size_i = 2'd0; cmd(1, 0, 0, 0, 3'd7, 8'h45); check("R2", 11'h045);
    cmd(0, 1, 1, 0, 3'd0, 8'h00); check("R4", 11'h046);
    cmd(0, 1, 1, 0, 3'd0, 8'h00); check("R4", 11'h047);
    cmd(0, 1, 1, 0, 3'd0, 8'h00); check("R5", 11'h040);
    size_i = 2'd3; cmd(1, 0, 0, 0, 3'd2, 8'h3E); check("R2", 11'h23E);
    cmd(0, 1, 1, 0, 3'd0, 8'h00); check("R4", 11'h23F);
    cmd(0, 1, 1, 0, 3'd0, 8'h00); check("R5", 11'h230);
  endtask

  task automatic t_read();
    size_i = 2'd0; cmd(1, 0, 0, 0, 3'd0, 8'h07);
    cmd(0, 1, 0, 0, 3'd0, 8'h00); check("R6", 11'h008);
    size_i = 2'd1; cmd(1, 0, 0, 0, 3'd1, 8'hFE); check("R2", 11'h1FE);
    cmd(0, 1, 0, 0, 3'd0, 8'h00); check("R6", 11'h1FF);
    cmd(0, 1, 0, 0, 3'd0, 8'h00); check("R7", 11'h000);
    size_i = 2'd2; cmd(1, 0, 0, 0, 3'd7, 8'hFF); check("R2", 11'h3FF);
    cmd(0, 1, 0, 0, 3'd0, 8'h00); check("R7", 11'h000);
    size_i = 2'd3; cmd(1, 0, 0, 0, 3'd7, 8'hFF); check("R2", 11'h7FF);
    cmd(0, 1, 0, 0, 3'd0, 8'h00); check("R7", 11'h000);
  endtask

  task automatic t_hold();
    size_i = 2'd3; cmd(1, 0, 0, 0, 3'd4, 8'h9C);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      check("R8", 11'h49C);
    end
  endtask

  task automatic t_priority();
    size_i = 2'd3;
    cmd(1, 1, 0, 0, 3'd1, 8'h10); check("R3", 11'h110);
    cmd(1, 1, 1, 1, 3'd6, 8'h22); check("R3", 11'h622);
  endtask

  task automatic t_cur_rd();
    size_i = 2'd3; cmd(1, 0, 0, 0, 3'd2, 8'hA5); check("R2", 11'h2A5);
    cmd(0, 0, 0, 1, 3'd6, 8'h00); check("R9", 11'h6A5);
    cmd(0, 1, 0, 1, 3'd1, 8'h00); check("R9", 11'h1A5);
    size_i = 2'd1;
    cmd(0, 0, 0, 1, 3'd0, 8'h00); check("R9", 11'h1A5);
    cmd(0, 1, 0, 0, 3'd0, 8'h00); check("R6", 11'h1A6);
  endtask

  initial begin
    rst_ni = 1'b1;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_load();
    t_write_page();
    t_read();
    t_hold();
    t_priority();
    t_cur_rd();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule